// File: doc/BRIEF.md
# Frame-Synchronized Serial Transmitter

The block sends parallel words out one bit at a time on a single data line. Words are grouped into frames, and each frame begins when a frame-sync edge is detected. A host places one word at a time into a single-entry holding register through a write strobe. The shift register takes its next word from that holding register only when the word currently on the line has been fully sent. The words of a frame follow each other with no idle bit between them. Between frames the line sits idle.

Configuration inputs set the following:
- the number of words per frame, up to 128;
- the word width;
- the active level of the sync;
- whether the sync comes from the sync pin or from an internal source.

With the internal source selected, the block drives the sync pin as an output. A one-cycle event flag marks every detected sync edge, and it keeps working while the transmitter is held in its local reset. If a frame needs a word while the holding register is empty, the block sends the previous word again and pulses an underflow flag.

The transmit bit clock is `clk`, and one bit leaves the block per rising edge.

Top module: `fsync_ser_tx`

## Requirements
- R1: A frame holds `cfg_frame_len`+1 words (1 to 128). During a frame, `dx_oe` stays high for exactly (`cfg_frame_len`+1) × word-width cycles in a row.
- R2: Bits leave the block most significant bit first, one per clock. The first bit appears on `dx` two clock edges after the sync input becomes active. The words of a frame follow each other with no idle cycle between them.
- R3: `cfg_word_sel` sets the word width as follows: 0 → 8 bits, 1 → 12, 2 → 16, 3 → 20, 4 → 24, 5 to 7 → 32. The bits sent are `wr_data[width-1:0]`.
- R4: A write is accepted only while `buf_full` is 0, and an accepted write sets `buf_full`. A write made while `buf_full` is 1 is discarded. The holding register is emptied only when a finished word has left the line, or when a frame starts.
- R5: With `cfg_fs_pol`=0 the sync is active high. With `cfg_fs_pol`=1 it is active low.
- R6: A frame starts only when the sync goes from inactive to active. A sync that stays active starts no further frame. A sync edge that arrives while a frame is in progress is ignored.
- R7: With `cfg_fs_internal`=1, the sync comes from `int_fs` (active high) and `fs_pin_in` is ignored. In this mode `fs_pin_oe`=1 and `fs_pin_out` = `int_fs` XOR `cfg_fs_pol`. With `cfg_fs_internal`=0, `fs_pin_oe`=0.
- R8: `fs_event` pulses for one cycle for each detected sync edge, including while `tx_reset` is high. While `tx_reset` is high, no frame starts and `dx_oe` is 0.
- R9: If a word is due while the holding register is empty, the previous word is sent again and `underflow` pulses for one cycle.
- R10: After reset, `dx` is 0, and `dx_oe`, `buf_full`, `fs_event` and `underflow` are all 0. Between frames `dx_oe` is 0 and `dx` holds the last bit that was sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_reset | input | 1 | Holds the transmitter idle; sync detection keeps running |
| cfg_frame_len | input | 7 | Words per frame minus one |
| cfg_word_sel | input | 3 | Word width code |
| cfg_fs_pol | input | 1 | Sync polarity, 1 = active low |
| cfg_fs_internal | input | 1 | 1 = internal sync source, pin driven |
| int_fs | input | 1 | Internal sync, active high |
| fs_pin_in | input | 1 | External sync pin input |
| fs_pin_out | output | 1 | Sync pin output value |
| fs_pin_oe | output | 1 | Sync pin output enable |
| wr_valid | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write word |
| buf_full | output | 1 | Holding register occupied |
| dx | output | 1 | Serial data out |
| dx_oe | output | 1 | High while a frame is being sent |
| fs_event | output | 1 | One-cycle pulse per detected sync edge |
| underflow | output | 1 | One-cycle pulse when a word is repeated |

## Verification
Two functions can land on the same clock edge: the start of a frame, and a host write into an empty holding register. On that edge the repeated previous word must go out first. The freshly written word must be kept and sent as the next word of the frame. The bench provokes this by driving the write strobe exactly one cycle after the sync becomes active. Its scoreboard expects the old word, then the new word, with exactly one underflow pulse. A second overlap places a fresh sync edge inside a running frame, and the bench judges it by seeing no extra bits and no restart.

// File: rtl/fstx_pkg.sv
package fstx_pkg;

   localparam int unsigned FSTX_SEL_W    = 3;
   localparam int unsigned FSTX_MAX_BITS = 32;

   // Width code to word width in bits.
   function automatic int unsigned fstx_word_bits(input logic [FSTX_SEL_W-1:0] sel);
      case (sel)
         3'd0:    return 8;
         3'd1:    return 12;
         3'd2:    return 16;
         3'd3:    return 20;
         3'd4:    return 24;
         default: return 32;
      endcase
   endfunction

endpackage

// File: rtl/fstx_fsync.sv
module fstx_fsync (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_internal,
   input  logic cfg_pol,
   input  logic pin_in,
   input  logic int_src,
   output logic pin_out,
   output logic pin_oe,
   output logic fs_edge,
   output logic fs_event
);

   logic active;
   logic seen_q;
   logic prev_q;

   // Normalised active-high sync
   assign active = cfg_internal ? int_src : (pin_in ^ cfg_pol);

   // Both stages reset to "active" so a sync held active through reset
   // must first go inactive before it can start a frame.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q   <= 1'b1;
         prev_q   <= 1'b1;
         fs_event <= 1'b0;
      end else begin
         seen_q   <= active;
         prev_q   <= seen_q;
         fs_event <= seen_q & ~prev_q;
      end
   end

   assign fs_edge = seen_q & ~prev_q;
   assign pin_oe  = cfg_internal;
   assign pin_out = cfg_internal & (int_src ^ cfg_pol);

endmodule

// File: rtl/fstx_holdbuf.sv
module fstx_holdbuf #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else if (clr) begin
         full <= 1'b0;
      end else if (wr_valid && !full) begin
         full <= 1'b1;
         data <= wr_data;
      end else if (take) begin
         full <= 1'b0;
      end
   end

endmodule

// File: rtl/fstx_shifter.sv
module fstx_shifter
   import fstx_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LEN_W     = 7,
   parameter bit          HOLD_IDLE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  start,
   input  logic [LEN_W-1:0]      cfg_len,
   input  logic [FSTX_SEL_W-1:0] cfg_sel,
   input  logic                  buf_full,
   input  logic [DATA_W-1:0]     buf_data,
   output logic                  take,
   output logic                  underflow,
   output logic                  dx,
   output logic                  busy
);

   localparam int unsigned CNT_W = $clog2(DATA_W);
   localparam int unsigned SH_W  = CNT_W + 1;

   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] last_word;
   logic [DATA_W-1:0] next_word;
   logic [CNT_W-1:0]  bit_cnt;
   logic [LEN_W-1:0]  words_left;
   logic [SH_W-1:0]   ws;
   logic [SH_W-1:0]   shamt;
   logic              busy_q;
   logic              under_q;
   logic              word_end;
   logic              frame_start;
   logic              chain;
   logic              load;

   assign ws          = SH_W'(fstx_word_bits(cfg_sel));
   assign shamt       = SH_W'(DATA_W) - ws;
   assign word_end    = busy_q && (bit_cnt == '0);
   assign frame_start = start && !busy_q;
   assign chain       = word_end && (words_left != '0);
   assign load        = frame_start || chain;
   assign take        = load && buf_full;
   assign next_word   = buf_full ? buf_data : last_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg      <= '0;
         last_word  <= '0;
         bit_cnt    <= '0;
         words_left <= '0;
         busy_q     <= 1'b0;
         under_q    <= 1'b0;
      end else if (clr) begin
         bit_cnt    <= '0;
         words_left <= '0;
         busy_q     <= 1'b0;
         under_q    <= 1'b0;
      end else begin
         under_q <= 1'b0;
         if (load) begin
            // Left-align so the word MSB sits at the output bit
            shreg      <= next_word << shamt;
            last_word  <= next_word;
            bit_cnt    <= CNT_W'(ws - SH_W'(1));
            under_q    <= !buf_full;
            busy_q     <= 1'b1;
            words_left <= frame_start ? cfg_len : words_left - 1'b1;
         end else if (word_end) begin
            busy_q <= 1'b0;
         end else if (busy_q) begin
            shreg   <= {shreg[DATA_W-2:0], 1'b0};
            bit_cnt <= bit_cnt - 1'b1;
         end
      end
   end

   if (HOLD_IDLE) begin : g_hold_idle
      assign dx = shreg[DATA_W-1];
   end else begin : g_zero_idle
      assign dx = busy_q & shreg[DATA_W-1];
   end

   assign busy      = busy_q;
   assign underflow = under_q;

endmodule

// File: rtl/fsync_ser_tx.sv
module fsync_ser_tx
   import fstx_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LEN_W     = 7,
   parameter bit          HOLD_IDLE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tx_reset,
   input  logic [LEN_W-1:0]      cfg_frame_len,
   input  logic [FSTX_SEL_W-1:0] cfg_word_sel,
   input  logic                  cfg_fs_pol,
   input  logic                  cfg_fs_internal,
   input  logic                  int_fs,
   input  logic                  fs_pin_in,
   output logic                  fs_pin_out,
   output logic                  fs_pin_oe,
   input  logic                  wr_valid,
   input  logic [DATA_W-1:0]     wr_data,
   output logic                  buf_full,
   output logic                  dx,
   output logic                  dx_oe,
   output logic                  fs_event,
   output logic                  underflow
);

   if (DATA_W < FSTX_MAX_BITS) begin : g_bad_data_w
      $error("fsync_ser_tx: DATA_W must hold the widest word");
   end
   if (LEN_W < 1) begin : g_bad_len_w
      $error("fsync_ser_tx: LEN_W must be at least 1");
   end

   logic              fs_edge;
   logic              take;
   logic [DATA_W-1:0] hold_data;

   fstx_fsync u_fsync (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_internal (cfg_fs_internal),
      .cfg_pol      (cfg_fs_pol),
      .pin_in       (fs_pin_in),
      .int_src      (int_fs),
      .pin_out      (fs_pin_out),
      .pin_oe       (fs_pin_oe),
      .fs_edge      (fs_edge),
      .fs_event     (fs_event)
   );

   fstx_holdbuf #(.DATA_W(DATA_W)) u_holdbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (tx_reset),
      .wr_valid (wr_valid),
      .wr_data  (wr_data),
      .take     (take),
      .full     (buf_full),
      .data     (hold_data)
   );

   fstx_shifter #(
      .DATA_W    (DATA_W),
      .LEN_W     (LEN_W),
      .HOLD_IDLE (HOLD_IDLE)
   ) u_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (tx_reset),
      .start     (fs_edge & ~tx_reset),
      .cfg_len   (cfg_frame_len),
      .cfg_sel   (cfg_word_sel),
      .buf_full  (buf_full),
      .buf_data  (hold_data),
      .take      (take),
      .underflow (underflow),
      .dx        (dx),
      .busy      (dx_oe)
   );

endmodule

// File: rtl/fstx_checker.sv
module fstx_checker #(
   parameter bit HOLD_IDLE = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic tx_reset,
   input logic fs_event,
   input logic underflow,
   input logic dx,
   input logic dx_oe
);

   AST_EVENT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      fs_event |=> !fs_event); // R8

   AST_RESET_STOPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      tx_reset |=> !dx_oe); // R8

   AST_UNDERFLOW_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> dx_oe); // R9

   AST_UNDERFLOW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> !underflow); // R9

   if (HOLD_IDLE) begin : g_idle_chk
      AST_IDLE_DX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !dx_oe |-> $stable(dx)); // R10
   end

endmodule

bind fsync_ser_tx fstx_checker #(.HOLD_IDLE(HOLD_IDLE)) u_fstx_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .tx_reset  (tx_reset),
   .fs_event  (fs_event),
   .underflow (underflow),
   .dx        (dx),
   .dx_oe     (dx_oe)
);

// File: tb/fsync_ser_tx_bench.sv
`timescale 1ns/1ps
module fsync_ser_tx_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_reset = 1'b0;
   logic [6:0]  cfg_frame_len = '0;
   logic [2:0]  cfg_word_sel = '0;
   logic        cfg_fs_pol = 1'b0;
   logic        cfg_fs_internal = 1'b0;
   logic        int_fs = 1'b0;
   logic        fs_pin_in = 1'b0;
   logic        wr_valid = 1'b0;
   logic [31:0] wr_data = '0;
   logic        fs_pin_out, fs_pin_oe, buf_full, dx, dx_oe, fs_event, underflow;

   always #2.5 clk = ~clk;

   fsync_ser_tx u_fsync_ser_tx (
      .clk(clk), .rst_n(rst_n), .tx_reset(tx_reset),
      .cfg_frame_len(cfg_frame_len), .cfg_word_sel(cfg_word_sel),
      .cfg_fs_pol(cfg_fs_pol), .cfg_fs_internal(cfg_fs_internal),
      .int_fs(int_fs), .fs_pin_in(fs_pin_in),
      .fs_pin_out(fs_pin_out), .fs_pin_oe(fs_pin_oe),
      .wr_valid(wr_valid), .wr_data(wr_data), .buf_full(buf_full),
      .dx(dx), .dx_oe(dx_oe), .fs_event(fs_event), .underflow(underflow)
   );

   int checks = 0;
   int errors = 0;
   int ev_cnt = 0;
   int exp_ev = 0;
   int uf_cnt = 0;
   int exp_uf = 0;
   int run = 0;
   bit done = 1'b0;
   bit exp_q[$];
   int run_q[$];
   logic [31:0] model_last = '0;
   bit          last_bit = 1'b0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int wbits(input logic [2:0] sel);
      case (sel)
         3'd0: return 8;
         3'd1: return 12;
         3'd2: return 16;
         3'd3: return 20;
         3'd4: return 24;
         default: return 32;
      endcase
   endfunction

   function automatic logic [31:0] word_of(input logic [31:0] seed, input int k);
      return seed ^ (32'(k) * 32'h9E37_79B9) ^ {16'h0, 8'(k), 8'h5A};
   endfunction

   // Scoreboard monitor: compares every driven bit and every frame length
   always @(negedge clk) begin
      if (rst_n) begin
         if (fs_event) ev_cnt++;
         if (underflow) uf_cnt++;
         if (dx_oe) begin
            if (exp_q.size() == 0) chk(1'b0, "R6 unexpected bit", 1, 0);
            else begin
               bit b;
               b = exp_q.pop_front();
               chk(dx == b, "R2 serial bit", dx, b);
            end
            run++;
         end else if (run > 0) begin
            if (run_q.size() == 0) chk(1'b0, "R6 unexpected frame", run, 0);
            else begin
               int e;
               e = run_q.pop_front();
               chk(run == e, "R1 frame length", run, e);
            end
            run = 0;
         end
      end
   end

   task automatic push_word(input logic [31:0] d, input int w);
      for (int i = w - 1; i >= 0; i--) exp_q.push_back(d[i]);
      model_last = d;
      last_bit = d[0];
   endtask

   task automatic host_write(input logic [31:0] d);
      @(negedge clk);
      while (buf_full) @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic sync_on();
      if (cfg_fs_internal) int_fs = 1'b1;
      else fs_pin_in = ~cfg_fs_pol;
      exp_ev++;
   endtask

   task automatic sync_off();
      if (cfg_fs_internal) int_fs = 1'b0;
      else fs_pin_in = cfg_fs_pol;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (dx_oe || exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic send_frame(input int n, input logic [2:0] sel, input logic [31:0] seed,
                             input bit hold, input string req);
      int w;
      w = wbits(sel);
      cfg_word_sel  = sel;
      cfg_frame_len = 7'(n - 1);
      host_write(word_of(seed, 0));
      for (int k = 0; k < n; k++) push_word(word_of(seed, k), w);
      run_q.push_back(n * w);
      @(negedge clk);
      sync_on();
      repeat (3) @(negedge clk);
      for (int k = 1; k < n; k++) host_write(word_of(seed, k));
      if (!hold) sync_off();
      wait_idle();
      chk(dx_oe == 1'b0, {req, " idle oe"}, dx_oe, 0);
      chk(dx == last_bit, "R10 idle holds last bit", dx, last_bit);
      chk(ev_cnt == exp_ev, "R8 event count", ev_cnt, exp_ev);
      chk(run_q.size() == 0, {req, " frame seen"}, run_q.size(), 0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(dx == 1'b0, "R10 reset dx", dx, 0);
      chk(dx_oe == 1'b0, "R10 reset dx_oe", dx_oe, 0);
      chk(buf_full == 1'b0, "R10 reset buf_full", buf_full, 0);
      chk(fs_event == 1'b0 && underflow == 1'b0, "R10 reset flags", {fs_event, underflow}, 0);
      chk(fs_pin_oe == 1'b0, "R7 external pin not driven", fs_pin_oe, 0);

      // R1 R2 R3 basic frames of several widths
      send_frame(1, 3'd0, 32'hC3A5_1E0F, 1'b0, "R1");
      send_frame(3, 3'd2, 32'h1234_ABCD, 1'b0, "R1");
      send_frame(2, 3'd5, 32'hDEAD_BEEF, 1'b0, "R3");
      send_frame(1, 3'd1, 32'h0F0F_6A6A, 1'b0, "R3");
      send_frame(2, 3'd3, 32'h7777_1357, 1'b0, "R3");
      send_frame(1, 3'd4, 32'h8642_9BDF, 1'b0, "R3");
      send_frame(1, 3'd7, 32'h5AA5_C33C, 1'b0, "R3");
      // R1 longest frame
      send_frame(128, 3'd0, 32'h2468_ACE1, 1'b0, "R1");

      // R5 active-low sync
      @(negedge clk);
      cfg_fs_pol = 1'b1;
      fs_pin_in  = 1'b1;
      repeat (3) @(negedge clk);
      chk(ev_cnt == exp_ev, "R5 inactive level no event", ev_cnt, exp_ev);
      send_frame(2, 3'd0, 32'h3C3C_9191, 1'b0, "R5");
      @(negedge clk);
      cfg_fs_pol = 1'b0;
      fs_pin_in  = 1'b0;
      repeat (3) @(negedge clk);

      // R6 sync held active: one frame only
      send_frame(1, 3'd2, 32'hAAAA_5555, 1'b1, "R6");
      repeat (40) @(negedge clk);
      chk(run_q.size() == 0 && exp_q.size() == 0, "R6 held sync no restart", exp_q.size(), 0);
      chk(ev_cnt == exp_ev, "R6 held sync one event", ev_cnt, exp_ev);
      sync_off();
      repeat (3) @(negedge clk);

      // R6 sync edge inside a running frame is ignored
      cfg_word_sel  = 3'd2;
      cfg_frame_len = 7'd1;
      host_write(32'h0000_F00D);
      push_word(32'h0000_F00D, 16);
      push_word(32'h0000_BEAD, 16);
      run_q.push_back(32);
      @(negedge clk);
      sync_on();
      repeat (3) @(negedge clk);
      sync_off();
      repeat (2) @(negedge clk);
      sync_on();
      host_write(32'h0000_BEAD);
      repeat (2) @(negedge clk);
      sync_off();
      wait_idle();
      chk(run_q.size() == 0, "R6 no restart mid-frame", run_q.size(), 0);
      chk(ev_cnt == exp_ev, "R8 events mid-frame", ev_cnt, exp_ev);

      // R4 write while full is discarded
      cfg_word_sel  = 3'd0;
      cfg_frame_len = 7'd0;
      host_write(32'h0000_00A7);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = 32'h0000_0019;
      @(negedge clk);
      wr_valid = 1'b0;
      chk(buf_full == 1'b1, "R4 full stays set", buf_full, 1);
      push_word(32'h0000_00A7, 8);
      run_q.push_back(8);
      @(negedge clk);
      sync_on();
      repeat (3) @(negedge clk);
      chk(buf_full == 1'b0, "R4 taken at frame start", buf_full, 0);
      sync_off();
      wait_idle();
      chk(run_q.size() == 0, "R4 only first word sent", run_q.size(), 0);

      // R9 empty buffer: repeat last word
      push_word(model_last, 8);
      run_q.push_back(8);
      exp_uf++;
      @(negedge clk);
      sync_on();
      repeat (3) @(negedge clk);
      sync_off();
      wait_idle();
      chk(uf_cnt == exp_uf, "R9 underflow pulse", uf_cnt, exp_uf);

      // R9 R4 frame start and host write on the same edge
      cfg_frame_len = 7'd1;
      push_word(model_last, 8);
      push_word(32'h0000_00C6, 8);
      run_q.push_back(16);
      exp_uf++;
      @(negedge clk);
      sync_on();
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = 32'h0000_00C6;
      @(negedge clk);
      wr_valid = 1'b0;
      repeat (2) @(negedge clk);
      sync_off();
      wait_idle();
      chk(uf_cnt == exp_uf, "R9 collision single underflow", uf_cnt, exp_uf);
      chk(buf_full == 1'b0, "R4 collision word consumed", buf_full, 0);

      // R8 event while transmitter held in reset, no frame
      @(negedge clk);
      tx_reset = 1'b1;
      repeat (2) @(negedge clk);
      sync_on();
      repeat (4) @(negedge clk);
      sync_off();
      repeat (4) @(negedge clk);
      chk(ev_cnt == exp_ev, "R8 event in reset", ev_cnt, exp_ev);
      chk(dx_oe == 1'b0, "R8 no frame in reset", dx_oe, 0);
      tx_reset = 1'b0;
      repeat (2) @(negedge clk);

      // R7 internal sync source
      int_fs = 1'b0;
      cfg_fs_internal = 1'b1;
      @(negedge clk);
      chk(fs_pin_oe == 1'b1, "R7 pin driven", fs_pin_oe, 1);
      chk(fs_pin_out == 1'b0, "R7 pin out low", fs_pin_out, 0);
      cfg_fs_pol = 1'b1;
      @(negedge clk);
      chk(fs_pin_out == 1'b1, "R7 pin out inverted", fs_pin_out, 1);
      cfg_fs_pol = 1'b0;
      fs_pin_in = 1'b1;
      repeat (3) @(negedge clk);
      fs_pin_in = 1'b0;
      repeat (3) @(negedge clk);
      chk(ev_cnt == exp_ev && dx_oe == 1'b0, "R7 pin ignored", ev_cnt, exp_ev);
      send_frame(2, 3'd2, 32'h6B6B_0C0C, 1'b0, "R7");
      @(negedge clk);
      cfg_fs_internal = 1'b0;
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0 && run_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule